// File: doc/BRIEF.md
# Four-Channel Timer/Counter with Compare Shortcuts

This block is a counting core with four compare/capture channels. It has two modes. In timer mode the count advances on a tick derived from the block clock through a power-of-two prescaler. In counter mode the count advances only when an explicit count pulse arrives. The counter width can be set to 8, 16, 24 or 32 bits, and the counter wraps at the width selected.

Each channel holds a compare value. A channel raises a sticky event flag when the counter steps onto that value. Per-channel link masks let a match zero the counter or halt the timer in the same cycle. A capture pulse copies the live count into a channel's register. Software can also write a channel's register directly. All control inputs are single-cycle pulses or plain levels. There is no data stream and no handshake at the edge.

Top module: `evt_timer`

## Requirements
- R1: While rst_n is low, count_val, running, evt_flag and every cc_val field are held at zero.
- R2: The prescaler is a free-running cycle count that starts at zero on the first clock after reset. A timer tick occurs on cycles where the low cfg_prescale bits of that count are all ones, which gives one tick every 2^cfg_prescale cycles. In timer mode (cfg_mode=0) with running high, the count rises by one on each tick. Otherwise it holds.
- R3: cfg_width_sel selects the counter width: 0 gives 16 bits, 1 gives 8 bits, 2 gives 24 bits and 3 gives 32 bits. A step from the all-ones value of that width wraps to zero.
- R4: task_start sets running only in timer mode. task_count adds one only in counter mode (cfg_mode=1), and it has no effect in timer mode.
- R5: When the counter steps onto the value in channel i's register, evt_flag[i] becomes 1. The flag stays 1 until a pulse on evt_clear[i].
- R6: While evt_flag[i] is 1, channel i produces no new match and triggers no link action.
- R7: When cfg_link_clr[i] is 1, a match on channel i sets the counter to zero in place of the step.
- R8: When cfg_link_halt[i] is 1, a match on channel i clears running.
- R9: task_stop or task_shutdown clears running. Either one takes precedence over task_start in the same cycle.
- R10: task_clear sets the counter to zero in the next cycle, whatever the mode, the running state and any step in that cycle.
- R11: task_capture[i] loads channel i's register with the count as it stood before that cycle's update. A capture takes precedence over a write to the same channel.
- R12: A write to channel i (cc_wr[i]) stores cc_wdata masked to the counter width currently selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, 16 MHz nominal |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 1 | 0 selects timer mode, 1 selects counter mode |
| cfg_width_sel | input | 2 | Counter width code |
| cfg_prescale | input | 4 | Prescaler shift; tick period is 2^value cycles |
| cfg_link_clr | input | 4 | Per channel: a match zeroes the counter |
| cfg_link_halt | input | 4 | Per channel: a match clears running |
| task_start | input | 1 | Start pulse |
| task_stop | input | 1 | Stop pulse |
| task_shutdown | input | 1 | Shutdown pulse, which also stops the timer |
| task_count | input | 1 | Count pulse for counter mode |
| task_clear | input | 1 | Counter clear pulse |
| task_capture | input | 4 | Per-channel capture pulses |
| evt_clear | input | 4 | Per-channel event flag clear pulses |
| cc_wr | input | 4 | Per-channel register write strobes |
| cc_wdata | input | 32 | Write data shared by all channels |
| count_val | output | 32 | Current counter value |
| running | output | 1 | Timer is running |
| cc_val | output | 128 | Channel registers; channel i is at bits 32*i+31 to 32*i |
| evt_flag | output | 4 | Sticky compare event flags |

## Verification
Several actions can land in the same cycle. A counter step can fire a match whose clear link zeroes the count in the very cycle a clear task also arrives. A capture pulse and a register write can target the same channel together. The same applies to a stop pulse and a start pulse, and to a halt link firing while a start is requested. The bench drives these pairs on purpose, on a match cycle it has predicted. A behavioural model applies the precedence stated in the requirements, and every output is compared with that model on every clock.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int CNT_W = 32;

  typedef enum logic {
    MODE_TIMER   = 1'b0,
    MODE_COUNTER = 1'b1
  } tmode_e;

  // Width code to value mask; code order is fixed by the configuration encoding.
  function automatic logic [CNT_W-1:0] width_mask(input logic [1:0] sel);
    case (sel)
      2'd0:    return 32'h0000_FFFF;
      2'd1:    return 32'h0000_00FF;
      2'd2:    return 32'h00FF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
  parameter int PSW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [PSW-1:0] shift,
  output logic           tick
);
  localparam int DIVW = (1 << PSW) - 1;

  logic [DIVW-1:0] div_q;
  logic [DIVW-1:0] sel_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  always_comb begin
    sel_mask = ~({DIVW{1'b1}} << shift);
    tick     = (div_q & sel_mask) == sel_mask;
  end
endmodule

// File: rtl/evt_channel.sv
module evt_channel #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_q,
  input  logic [W-1:0] cnt_nx,
  input  logic         adv,
  input  logic         cap,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic         ev_clr,
  output logic [W-1:0] cc_q,
  output logic         flag_q,
  output logic         hit
);
  // A set flag masks further matches until software clears it.
  always_comb hit = adv && (cnt_nx == cc_q) && !flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cc_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cap)     cc_q <= cnt_q;
      else if (wr) cc_q <= wr_data;
      flag_q <= (flag_q & ~ev_clr) | hit;
    end
  end

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !ev_clr |=> flag_q); // R5
  AST_CAP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> cc_q == $past(cnt_q)); // R11
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int NCH = 4,
  parameter int PSW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_mode,
  input  logic [1:0]           cfg_width_sel,
  input  logic [PSW-1:0]       cfg_prescale,
  input  logic [NCH-1:0]       cfg_link_clr,
  input  logic [NCH-1:0]       cfg_link_halt,
  input  logic                 task_start,
  input  logic                 task_stop,
  input  logic                 task_shutdown,
  input  logic                 task_count,
  input  logic                 task_clear,
  input  logic [NCH-1:0]       task_capture,
  input  logic [NCH-1:0]       evt_clear,
  input  logic [NCH-1:0]       cc_wr,
  input  logic [CNT_W-1:0]     cc_wdata,
  output logic [CNT_W-1:0]     count_val,
  output logic                 running,
  output logic [NCH*CNT_W-1:0] cc_val,
  output logic [NCH-1:0]       evt_flag
);
  logic [CNT_W-1:0] cnt_q, cnt_nx, wmask;
  logic             run_q, tick, adv, is_timer, link_clr, link_halt;
  logic [NCH-1:0]   hits;

  evt_prescaler #(.PSW(PSW)) u_presc (
    .clk(clk), .rst_n(rst_n), .shift(cfg_prescale), .tick(tick)
  );

  always_comb begin
    is_timer  = tmode_e'(cfg_mode) == MODE_TIMER;
    wmask     = width_mask(cfg_width_sel);
    adv       = is_timer ? (run_q && tick) : task_count;
    cnt_nx    = (cnt_q + CNT_W'(adv)) & wmask;
    link_clr  = |(hits & cfg_link_clr);
    link_halt = |(hits & cfg_link_halt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (task_clear || link_clr) cnt_q <= '0;
      else if (adv)               cnt_q <= cnt_nx;
      if (task_stop || task_shutdown || link_halt) run_q <= 1'b0;
      else if (task_start && is_timer)              run_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    evt_channel #(.W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q), .cnt_nx(cnt_nx), .adv(adv),
      .cap(task_capture[i]), .wr(cc_wr[i]), .wr_data(cc_wdata & wmask),
      .ev_clr(evt_clear[i]), .cc_q(cc_val[i*CNT_W +: CNT_W]),
      .flag_q(evt_flag[i]), .hit(hits[i])
    );
  end

  assign count_val = cnt_q;
  assign running   = run_q;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    task_clear |=> cnt_q == '0); // R10
  AST_HALT_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    |(hits & cfg_link_halt) |=> !run_q); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && !task_count && !task_clear |=> $stable(cnt_q)); // R2
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    adv && cnt_q == wmask |=> cnt_q == '0); // R3
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    task_stop || task_shutdown |=> !run_q); // R9
endmodule

// File: tb/tb_evt_timer.sv
module tb_evt_timer;
  logic clk = 0, rst_n = 0;
  logic cfg_mode = 0;
  logic [1:0] cfg_width_sel = 0;
  logic [3:0] cfg_prescale = 0, cfg_link_clr = 0, cfg_link_halt = 0;
  logic task_start = 0, task_stop = 0, task_shutdown = 0, task_count = 0, task_clear = 0;
  logic [3:0] task_capture = 0, evt_clear = 0, cc_wr = 0;
  logic [31:0] cc_wdata = 0;
  logic [31:0] count_val;
  logic running;
  logic [127:0] cc_val;
  logic [3:0] evt_flag;

  evt_timer dut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  string tag = "R1";
  bit done = 0;

  longint m_cnt = 0, m_div = 0;
  longint m_cc[4] = '{0, 0, 0, 0};
  bit m_run = 0;
  bit m_flg[4] = '{0, 0, 0, 0};

  function automatic longint wmask(int sel);
    case (sel)
      0: return 64'hFFFF;
      1: return 64'hFF;
      2: return 64'hFF_FFFF;
      default: return 64'hFFFF_FFFF;
    endcase
  endfunction

  task automatic cmp(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    longint pm = (64'd1 << cfg_prescale) - 1;
    longint mk = wmask(cfg_width_sel);
    bit tick = ((m_div & pm) == pm);
    bit inc = (cfg_mode == 0) ? (m_run && tick) : task_count;
    longint nx = (m_cnt + 1) & mk;
    bit lclr = 0, lhalt = 0;
    bit mt[4];
    longint old = m_cnt;
    m_div = (m_div + 1) & 64'h7FFF;
    for (int i = 0; i < 4; i++) begin
      mt[i] = inc && (nx == m_cc[i]) && !m_flg[i];
      if (mt[i] && cfg_link_clr[i]) lclr = 1;
      if (mt[i] && cfg_link_halt[i]) lhalt = 1;
    end
    if (task_clear || lclr) m_cnt = 0;
    else if (inc) m_cnt = nx;
    if (task_stop || task_shutdown || lhalt) m_run = 0;
    else if (task_start && cfg_mode == 0) m_run = 1;
    for (int i = 0; i < 4; i++) begin
      m_flg[i] = (m_flg[i] && !evt_clear[i]) || mt[i];
      if (task_capture[i]) m_cc[i] = old;
      else if (cc_wr[i]) m_cc[i] = cc_wdata & mk;
    end
  endtask

  task automatic compare_all();
    cmp("count_val", count_val, m_cnt);
    cmp("running", running, m_run);
    for (int i = 0; i < 4; i++) begin
      cmp("cc_val", cc_val[i*32 +: 32], m_cc[i]);
      cmp("evt_flag", evt_flag[i], m_flg[i]);
    end
  endtask

  task automatic cyc(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all();
      task_start = 0; task_stop = 0; task_shutdown = 0; task_count = 0;
      task_clear = 0; task_capture = 0; evt_clear = 0; cc_wr = 0;
    end
  endtask

  task automatic wr_cc(int ch, longint v);
    cc_wr[ch] = 1; cc_wdata = v[31:0]; cyc(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state, even with pulses applied
    task_start = 1; task_count = 1;
    repeat (3) @(negedge clk);
    tag = "R1";
    cmp("count_val", count_val, 0);
    cmp("running", running, 0);
    cmp("cc_val", cc_val, 0);
    cmp("evt_flag", evt_flag, 0);
    task_start = 0; task_count = 0;
    rst_n = 1;
    cyc(2);

    // R2 R3: timer mode, 8-bit width, prescale 0 then 3, wraps
    tag = "R3";
    cfg_width_sel = 1; task_start = 1; cyc(300);
    tag = "R2";
    cfg_prescale = 3; cyc(2200);
    cfg_prescale = 1; cyc(60);

    // R12: write masking per width code
    tag = "R12";
    task_stop = 1; cyc(1);
    for (int s = 0; s < 4; s++) begin
      cfg_width_sel = s[1:0];
      wr_cc(s, 64'hFFFF_FFFF);
    end
    cmp("cc_val[3]", cc_val[127:96], 32'hFFFF_FFFF);
    cmp("cc_val[1]", cc_val[63:32], 32'hFF);

    // R5 R7 R6: compare with clear link on channel 0
    tag = "R7";
    cfg_width_sel = 1; cfg_prescale = 0; task_clear = 1; cyc(1);
    wr_cc(0, 20); wr_cc(1, 200); wr_cc(2, 250); wr_cc(3, 255);
    cfg_link_clr = 4'b0001; task_start = 1; cyc(25);
    tag = "R5";
    cfg_link_clr = 4'b0001; cyc(30);
    tag = "R6";
    cyc(260);
    evt_clear = 4'b1111; cyc(300);

    // R8: halt link on channel 1
    tag = "R8";
    cfg_link_clr = 0; cfg_link_halt = 4'b0010; evt_clear = 4'b1111;
    task_clear = 1; task_start = 1; cyc(230);
    cmp("running after halt", running, 0);
    task_start = 1; cyc(20);

    // R9: stop, shutdown, stop with start
    tag = "R9";
    cfg_link_halt = 0; task_start = 1; cyc(10);
    task_stop = 1; cyc(5);
    task_start = 1; cyc(5);
    task_shutdown = 1; cyc(3);
    task_start = 1; task_stop = 1; cyc(3);
    cmp("running stop-vs-start", running, 0);

    // R4: counter mode
    tag = "R4";
    cfg_mode = 1; task_start = 1; cyc(2);
    cmp("start ignored in counter mode", running, 0);
    for (int k = 0; k < 40; k++) begin task_count = 1; cyc(1); cyc(1); end
    cfg_mode = 0; task_start = 1; cyc(1);
    task_stop = 1; cyc(1);
    task_count = 1; cyc(3);

    // R10: clear while running and coinciding with a clear-link match
    tag = "R10";
    cfg_mode = 1; evt_clear = 4'b1111; task_clear = 1; cyc(1);
    wr_cc(0, 5); cfg_link_clr = 4'b0001;
    for (int k = 0; k < 4; k++) begin task_count = 1; cyc(1); end
    task_count = 1; task_clear = 1; cyc(1);
    cmp("clear with match", count_val, 0);
    cfg_mode = 0; cfg_link_clr = 0; evt_clear = 4'b1111; task_start = 1; cyc(50);
    task_clear = 1; cyc(10);

    // R11: capture while running, capture with write on same channel
    tag = "R11";
    task_capture = 4'b0100; cyc(3);
    task_capture = 4'b1000; cc_wr = 4'b1000; cc_wdata = 32'h12; cyc(3);
    task_capture = 4'b0011; cc_wr = 4'b0010; cc_wdata = 32'h7; cyc(5);
    task_stop = 1; cyc(2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule